// File: doc/BRIEF.md
# Conditional Flag-Setting Data-Processing ALU

This block is the data-processing stage of a small RISC core. Each cycle it takes an opcode, a first operand, a second operand that has already passed through the operand shifter, the shifter's carry-out, the current negative/zero/carry/overflow flags, a set-flags request and a four-bit condition field. It computes the arithmetic, logical, move or compare operation. On the next clock edge it presents the result, the flag word the core should keep, a destination write-enable and a condition-pass indication.

The condition field is tested against the incoming flags. When the test fails, the instruction has no architectural effect: nothing is written and the flags pass through unchanged. Compare-type opcodes change only the flags. Subtraction reports its carry as "no borrow". The overflow flag is changed only by arithmetic.

Top module: `flag_alu`

## Requirements
- R1: Arithmetic opcodes give the result modulo 2^W: ADD=0100 (A+B), SUB=0010 (A-B), RSB=0011 (B-A), ADC=0101 (A+B+C), SBC=0110 (A-B-1+C), RSC=0111 (B-A-1+C), where C is the incoming carry flag.
- R2: Logical and move opcodes give AND=0000 (A&B), EOR=0001 (A^B), MOV=1101 (B) and MVN=1111 (~B).
- R3: For subtracting opcodes, the carry out is the carry of the minuend plus the inverted subtrahend plus the carry-in, so C=1 means no borrow (A>=B for SUB and CMP).
- R4: An arithmetic flag update sets N to the result's top bit, Z when the result is zero, C to the adder carry-out and V on signed overflow.
- R5: A logical or move flag update sets N and Z from the result, takes C from the shifter carry input and keeps V unchanged.
- R6: TST=1000 (A&B), TEQ=1001 (A^B), CMP=1010 (A-B) and CMN=1011 (A+B) update the flags whatever the set-flags bit is, and never raise the write-enable.
- R7: A non-compare opcode with the set-flags bit clear leaves the flags unchanged.
- R8: The condition codes are EQ=0000 Z, NE=0001 !Z, HS=0010 C, LO=0011 !C, MI=0100 N, PL=0101 !N, VS=0110 V, VC=0111 !V, HI=1000 C&!Z, LS=1001 !C|Z, GE=1010 N==V, LT=1011 N!=V, GT=1100 !Z&(N==V), LE=1101 Z|(N!=V), AL=1110 always. The flag word is {N,Z,C,V}, with N in bit 3 and V in bit 0.
- R9: Condition code 1111 never passes.
- R10: When the condition fails, the write-enable is low and the output flags equal the input flags.
- R11: The unassigned opcodes 1100 and 1110 write nothing and leave the flags unchanged.
- R12: A synchronous reset clears the result, flags, write-enable and pass outputs.
- R13: Every output is registered and changes one clock edge after its inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | W | First operand |
| b_i | input | W | Shifted second operand |
| shc_i | input | 1 | Shifter carry-out |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| setf_i | input | 1 | Set-flags request |
| cond_i | input | 4 | Condition field |
| result_o | output | W | Registered result |
| flags_o | output | 4 | Registered next flags {N,Z,C,V} |
| wr_en_o | output | 1 | Destination write-enable |
| pass_o | output | 1 | Condition passed |

## Verification
All four outputs come from one register stage, so each one is due on the first rising edge after the inputs that produce it. The bench applies inputs on a falling edge and reads the outputs 1 ns after the next rising edge. For the latency requirement, it also reads the outputs just after applying new inputs, before that edge, and expects the previous values. The condition table is checked for all sixteen codes against every flag combination. Each combination is read on the edge that follows it.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'b0000, OP_EOR = 4'b0001, OP_SUB = 4'b0010, OP_RSB = 4'b0011,
    OP_ADD = 4'b0100, OP_ADC = 4'b0101, OP_SBC = 4'b0110, OP_RSC = 4'b0111,
    OP_TST = 4'b1000, OP_TEQ = 4'b1001, OP_CMP = 4'b1010, OP_CMN = 4'b1011,
    OP_NA0 = 4'b1100, OP_MOV = 4'b1101, OP_NA1 = 4'b1110, OP_MVN = 4'b1111
  } op_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_HS = 4'h2, CC_LO = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef enum logic [1:0] {
    CLS_LOGIC = 2'd0,
    CLS_ARITH = 2'd1,
    CLS_NONE  = 2'd2
  } op_class_e;

  function automatic op_class_e op_class(input op_e op);
    case (op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC,
      OP_CMP, OP_CMN:                                  return CLS_ARITH;
      OP_AND, OP_EOR, OP_TST, OP_TEQ, OP_MOV, OP_MVN:  return CLS_LOGIC;
      default:                                         return CLS_NONE;
    endcase
  endfunction

  function automatic logic op_is_compare(input op_e op);
    return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
  endfunction

endpackage

// File: rtl/flag_alu_cond.sv
module flag_alu_cond
  import flag_alu_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       pass_o
);
  logic ge;
  assign ge = (flags_i.n == flags_i.v);

  always_comb begin
    case (cond_e'(cond_i))
      CC_EQ:   pass_o = flags_i.z;
      CC_NE:   pass_o = !flags_i.z;
      CC_HS:   pass_o = flags_i.c;
      CC_LO:   pass_o = !flags_i.c;
      CC_MI:   pass_o = flags_i.n;
      CC_PL:   pass_o = !flags_i.n;
      CC_VS:   pass_o = flags_i.v;
      CC_VC:   pass_o = !flags_i.v;
      CC_HI:   pass_o = flags_i.c && !flags_i.z;
      CC_LS:   pass_o = !flags_i.c || flags_i.z;
      CC_GE:   pass_o = ge;
      CC_LT:   pass_o = !ge;
      CC_GT:   pass_o = !flags_i.z && ge;
      CC_LE:   pass_o = flags_i.z || !ge;
      CC_AL:   pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/flag_alu_adder.sv
module flag_alu_adder
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] x, y;
  logic         cin;
  logic [W:0]   total;

  always_comb begin
    x   = a_i;
    y   = b_i;
    cin = 1'b0;
    case (op_i)
      OP_SUB, OP_CMP: begin y = ~b_i; cin = 1'b1; end
      OP_RSB:         begin x = b_i; y = ~a_i; cin = 1'b1; end
      OP_ADC:         begin cin = c_i; end
      OP_SBC:         begin y = ~b_i; cin = c_i; end
      OP_RSC:         begin x = b_i; y = ~a_i; cin = c_i; end
      default:        begin cin = 1'b0; end
    endcase
  end

  assign total  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
  assign sum_o  = total[W-1:0];
  assign cout_o = total[W];
  assign ovf_o  = (x[MSB] == y[MSB]) && (total[MSB] != x[MSB]);
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_MOV:         res_o = b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         shc_i,
  input  logic [3:0]   flags_i,
  input  logic         setf_i,
  input  logic [3:0]   cond_i,
  output logic [W-1:0] result_o,
  output logic [3:0]   flags_o,
  output logic         wr_en_o,
  output logic         pass_o
);
  localparam int MSB = W - 1;

  op_e          op;
  flags_t       cur;
  op_class_e    cls;
  logic         is_cmp;
  logic         cond_ok;
  logic [W-1:0] sum, lres, res;
  logic         cout, ovf;
  flags_t       nf;
  logic         upd;

  assign op     = op_e'(op_i);
  assign cur    = flags_t'(flags_i);
  assign cls    = op_class(op);
  assign is_cmp = op_is_compare(op);

  flag_alu_cond u_cond (
    .cond_i (cond_i),
    .flags_i(cur),
    .pass_o (cond_ok)
  );

  flag_alu_adder #(.W(W)) u_add (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .c_i   (cur.c),
    .sum_o (sum),
    .cout_o(cout),
    .ovf_o (ovf)
  );

  flag_alu_logic #(.W(W)) u_log (
    .op_i (op),
    .a_i  (a_i),
    .b_i  (b_i),
    .res_o(lres)
  );

  always_comb begin
    res = (cls == CLS_ARITH) ? sum : lres;
    nf.n = res[MSB];
    nf.z = (res == '0);
    nf.c = (cls == CLS_ARITH) ? cout : shc_i;
    nf.v = (cls == CLS_ARITH) ? ovf : cur.v;
    upd  = cond_ok && (cls != CLS_NONE) && (setf_i || is_cmp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      flags_o  <= '0;
      wr_en_o  <= 1'b0;
      pass_o   <= 1'b0;
    end else begin
      result_o <= res;
      flags_o  <= upd ? nf : cur;
      wr_en_o  <= cond_ok && (cls != CLS_NONE) && !is_cmp;
      pass_o   <= cond_ok;
    end
  end

  // R10: a failed condition suppresses the write
  assert_fail_nowrite_R10: assert property (@(posedge clk) disable iff (rst)
    !pass_o |-> !wr_en_o);

  // R10: a failed condition passes the flags through
  assert_fail_flags_R10: assert property (@(posedge clk) disable iff (rst)
    !cond_ok |=> (flags_o == $past(flags_i)));

  // R9: never-execute code never passes
  assert_never_R9: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'hF) |=> !pass_o);

  // R6: compare opcodes never write
  assert_cmp_nowrite_R6: assert property (@(posedge clk) disable iff (rst)
    (op_i[3:2] == 2'b10) |=> !wr_en_o);

  // R5: logical flag updates keep V
  assert_logic_keepv_R5: assert property (@(posedge clk) disable iff (rst)
    (cls == CLS_LOGIC) |=> (flags_o[0] == $past(flags_i[0])));

  // R4: Z follows the registered result on arithmetic updates
  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (cond_ok && setf_i && cls == CLS_ARITH) |=> (flags_o[2] == (result_o == '0)));

  // R7: no set-flags request on a non-compare keeps flags
  assert_nos_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (!setf_i && !(op_i[3:2] == 2'b10)) |=> (flags_o == $past(flags_i)));
endmodule

// File: tb/flag_alu_bench.sv
`timescale 1ns/1ps
module flag_alu_bench;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_i = '0;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic         shc_i = 1'b0;
  logic [3:0]   flags_i = '0;
  logic         setf_i = 1'b0;
  logic [3:0]   cond_i = 4'hE;
  logic [W-1:0] result_o;
  logic [3:0]   flags_o;
  logic         wr_en_o;
  logic         pass_o;

  int checks = 0;
  int failures = 0;

  localparam logic [3:0] AND_ = 4'b0000, EOR_ = 4'b0001, SUB_ = 4'b0010, RSB_ = 4'b0011,
                         ADD_ = 4'b0100, ADC_ = 4'b0101, SBC_ = 4'b0110, RSC_ = 4'b0111,
                         TST_ = 4'b1000, TEQ_ = 4'b1001, CMP_ = 4'b1010, CMN_ = 4'b1011,
                         MOV_ = 4'b1101, MVN_ = 4'b1111, AL = 4'hE;

  always #2 clk = ~clk;

  flag_alu #(.W(W)) u_flag_alu (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i), .shc_i(shc_i),
    .flags_i(flags_i), .setf_i(setf_i), .cond_i(cond_i),
    .result_o(result_o), .flags_o(flags_o), .wr_en_o(wr_en_o), .pass_o(pass_o)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [3:0] f, input logic s, input logic [3:0] cc, input logic sh);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; flags_i = f; setf_i = s; cond_i = cc; shc_i = sh;
    @(posedge clk);
    #1;
  endtask

  task automatic run(input string tag, input logic [3:0] op, input logic [W-1:0] a,
                     input logic [W-1:0] b, input logic [3:0] f, input logic s,
                     input logic [3:0] cc, input logic sh, input logic chk_res,
                     input logic [W-1:0] er, input logic [3:0] ef, input logic ew, input logic ep);
    apply(op, a, b, f, s, cc, sh);
    if (chk_res) check({tag, " result"}, result_o, er);
    check({tag, " flags"}, {28'd0, flags_o}, {28'd0, ef});
    check({tag, " wr_en"}, {31'd0, wr_en_o}, {31'd0, ew});
    check({tag, " pass"},  {31'd0, pass_o},  {31'd0, ep});
  endtask

  task automatic t_reset();
    check("R12 reset result", result_o, '0);
    check("R12 reset flags", {28'd0, flags_o}, '0);
    check("R12 reset wr_en", {31'd0, wr_en_o}, '0);
    check("R12 reset pass", {31'd0, pass_o}, '0);
  endtask

  task automatic t_arith();
    run("R1 ADD", ADD_, 5, 7, 4'b0000, 1, AL, 0, 1, 12, 4'b0000, 1, 1);
    run("R4 ADD ovf", ADD_, 32'h7FFFFFFF, 1, 4'b0000, 1, AL, 0, 1, 32'h80000000, 4'b1001, 1, 1);
    run("R4 ADD wrap", ADD_, 32'hFFFFFFFF, 1, 4'b0000, 1, AL, 0, 1, 0, 4'b0110, 1, 1);
    run("R1 RSB", RSB_, 3, 10, 4'b0000, 1, AL, 0, 1, 7, 4'b0010, 1, 1);
    run("R1 ADC", ADC_, 1, 2, 4'b0010, 1, AL, 0, 1, 4, 4'b0000, 1, 1);
    run("R1 RSC", RSC_, 3, 10, 4'b0010, 1, AL, 0, 1, 7, 4'b0010, 1, 1);
  endtask

  task automatic t_borrow();
    run("R3 SUB nb", SUB_, 5, 3, 4'b0000, 1, AL, 0, 1, 2, 4'b0010, 1, 1);
    run("R3 SUB borrow", SUB_, 3, 5, 4'b0000, 1, AL, 0, 1, 32'hFFFFFFFE, 4'b1000, 1, 1);
    run("R3 SUB equal", SUB_, 5, 5, 4'b0000, 1, AL, 0, 1, 0, 4'b0110, 1, 1);
    run("R3 SBC", SBC_, 5, 3, 4'b0000, 1, AL, 0, 1, 1, 4'b0010, 1, 1);
  endtask

  task automatic t_logic();
    run("R5 AND", AND_, 32'hF0F0, 32'hFF00, 4'b0001, 1, AL, 1, 1, 32'hF000, 4'b0011, 1, 1);
    run("R7 EOR nos", EOR_, 32'h55, 32'h0F, 4'b1010, 0, AL, 1, 1, 32'h5A, 4'b1010, 1, 1);
    run("R5 MOV", MOV_, 0, 32'h80000000, 4'b0011, 1, AL, 0, 1, 32'h80000000, 4'b1001, 1, 1);
    run("R2 MVN", MVN_, 0, 0, 4'b0000, 1, AL, 1, 1, 32'hFFFFFFFF, 4'b1010, 1, 1);
  endtask

  task automatic t_compare();
    run("R6 CMP", CMP_, 3, 5, 4'b0000, 0, AL, 0, 0, 0, 4'b1000, 0, 1);
    run("R6 CMN", CMN_, 32'hFFFFFFFF, 1, 4'b0000, 0, AL, 0, 0, 0, 4'b0110, 0, 1);
    run("R6 TST", TST_, 32'hF0, 32'h0F, 4'b0001, 1, AL, 0, 0, 0, 4'b0101, 0, 1);
    run("R6 TEQ", TEQ_, 5, 5, 4'b0000, 0, AL, 1, 0, 0, 4'b0110, 0, 1);
  endtask

  function automatic logic exp_pass(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'h0: return z;          4'h1: return !z;
      4'h2: return c;          4'h3: return !c;
      4'h4: return n;          4'h5: return !n;
      4'h6: return v;          4'h7: return !v;
      4'h8: return c && !z;    4'h9: return !c || z;
      4'hA: return n == v;     4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic t_conditions();
    for (int cc = 0; cc < 16; cc++) begin
      for (int f = 0; f < 16; f++) begin
        logic ep;
        ep = exp_pass(cc[3:0], f[3:0]);
        apply(ADD_, 32'h80000000, 32'h80000000, f[3:0], 1, cc[3:0], 0);
        check((cc == 15) ? "R9 never pass" : "R8 cond pass", {31'd0, pass_o}, {31'd0, ep});
        check("R10 cond wr_en", {31'd0, wr_en_o}, {31'd0, ep});
        if (!ep) check("R10 cond flags kept", {28'd0, flags_o}, {28'd0, f[3:0]});
        else     check("R4 cond flags", {28'd0, flags_o}, {28'd0, 4'b0111});
      end
    end
  endtask

  task automatic t_unassigned();
    run("R11 op 1100", 4'b1100, 1, 2, 4'b1010, 1, AL, 1, 0, 0, 4'b1010, 0, 1);
    run("R11 op 1110", 4'b1110, 1, 2, 4'b0101, 1, AL, 1, 0, 0, 4'b0101, 0, 1);
  endtask

  task automatic t_latency();
    apply(ADD_, 1, 1, 4'b0000, 1, AL, 0);
    check("R13 first", result_o, 2);
    @(negedge clk);
    op_i = ADD_; a_i = 10; b_i = 20; flags_i = 4'b0000; setf_i = 1; cond_i = AL;
    #1;
    check("R13 held before edge", result_o, 2);
    @(posedge clk);
    #1;
    check("R13 after edge", result_o, 30);
  endtask

  initial begin
    #400000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_arith();
    t_borrow();
    t_logic();
    t_compare();
    t_unassigned();
    t_latency();
    t_conditions();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule